// File: doc/BRIEF.md
# Tiled Framebuffer Scan Address Generator

This block turns a programmed framebuffer description into a stream of memory read requests for display scan-out. The framebuffer is stored as tiles that are 512 bytes wide and as tall as the screen. On each start-of-line pulse the generator walks the current line from left to right, one tile at a time. For each tile it issues one burst request made of a byte address and a byte length, held under a valid/ready handshake. A linear mode is also available. In that mode the line's bursts sit back to back in memory and the lines follow one another.

The base of the buffer is given as a tile pointer, which is the physical byte address divided by 512. The pixel depth sets how many pixels fit in one tile: 512 divided by the bytes per pixel. From that and the screen width in pixels the block works out how many tiles a line covers, and how many bytes the final, possibly partial, tile holds. Software writes the fetch enable at any time, but the enable only takes effect at start-of-frame, and a status output shows the enable the hardware has actually accepted. A separate control bit, set and then cleared, produces a one-cycle flush pulse for the downstream fetch FIFO.

Top module: `scan_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_valid`, `dma_active` and `fifo_flush` are 0.
- R2: `cfg_depth` code 0 selects 1 byte per pixel, code 1 selects 2 bytes, and codes 2 and 3 select 4 bytes. Pixels per tile are 512 divided by the bytes per pixel. Each fetched line issues ceil(`cfg_width_pix` / pixels per tile) bursts.
- R3: With `cfg_linear`=0, burst t of line y has the address (ptr + t*H + y)*512, where ptr is the tile pointer and H is the programmed height in lines.
- R4: With `cfg_linear`=1, burst t of line y has the address (ptr + y*T + t)*512, where T is the number of tiles per line.
- R5: Every burst except the last in a line has a length of 512 bytes. The last has a length equal to the leftover pixels times the bytes per pixel, or 512 when the width fills the tile exactly. Every length lies in 1..512.
- R6: The first request of a line is valid in the cycle after `sol` is sampled. After each cycle with `req_valid` and `req_ready` both high, the next tile is presented in the following cycle, or `req_valid` drops after the last tile. While `req_ready` is low, the valid, address and length all hold.
- R7: A change of `cfg_dma_en` is accepted only at a sampled `sof`, and `dma_active` shows the accepted value from the next cycle on. When `dma_active` is 0, `sol` issues no requests. Turning the enable off in mid-frame lets the current frame finish fetching.
- R8: Pointer, width, depth, height and the linear bit are captured at `sof`. Changes made within a frame have no effect until the next `sof`.
- R9: A `sol` after H lines of the frame have been fetched is ignored. A `sol` that arrives while a line is still being issued is ignored.
- R10: When `cfg_fifo_rst` is sampled low after having been sampled high, `fifo_flush` is high for exactly one cycle, namely the next one.
- R11: A `sof` drops any line in progress and restarts the line count at line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tile_ptr | input | PTR_W | Buffer base, byte address divided by 512 |
| cfg_width_pix | input | WID_W | Screen width in pixels |
| cfg_height | input | HGT_W | Screen height in lines (H) |
| cfg_depth | input | 2 | Pixel depth code (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| cfg_linear | input | 1 | 1 selects linear addressing, 0 selects tiled |
| cfg_dma_en | input | 1 | Requested fetch enable |
| cfg_fifo_rst | input | 1 | FIFO reset control bit |
| sof | input | 1 | Start-of-frame pulse (vertical blank) |
| sol | input | 1 | Start-of-line pulse |
| req_ready | input | 1 | Memory accepts the current request |
| req_addr | output | PTR_W+9 | Burst byte address |
| req_len | output | 10 | Burst length in bytes |
| req_valid | output | 1 | Request valid |
| dma_active | output | 1 | Enable as accepted by hardware |
| fifo_flush | output | 1 | One-cycle fetch FIFO flush |

## Verification
Each result has its own latency. A request appears one cycle after `sol` is sampled, each further tile appears one cycle after an accepted handshake, `dma_active` changes one cycle after `sof` is sampled, and `fifo_flush` rises one cycle after the control bit is sampled low. The bench drives all inputs on the falling clock edge and checks outputs on the next falling edge after the rising edge that captured them. Bursts are checked one per falling edge while `req_ready` is held high, and the bench counts the edges during backpressure, so every expected address and length is compared in the exact cycle it is due.

// File: rtl/scan_addr_pkg.sv
package scan_addr_pkg;
  localparam int TILE_BYTES = 512;
  localparam int TILE_SHIFT = 9;
  localparam int LEN_W      = 10;

  typedef enum logic [1:0] {
    DEPTH_8   = 2'd0,
    DEPTH_16  = 2'd1,
    DEPTH_32  = 2'd2,
    DEPTH_32B = 2'd3
  } depth_e;

  // log2 of bytes per pixel for a depth code
  function automatic logic [1:0] bpp_log2(input logic [1:0] code);
    case (depth_e'(code))
      DEPTH_8:  bpp_log2 = 2'd0;
      DEPTH_16: bpp_log2 = 2'd1;
      default:  bpp_log2 = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/scan_geom.sv
module scan_geom
  import scan_addr_pkg::*;
#(
  parameter int WID_W = 12
) (
  input  logic [1:0]       depth,
  input  logic [WID_W-1:0] width_pix,
  output logic [WID_W-1:0] tiles,
  output logic [LEN_W-1:0] last_len
);
  localparam int EXT_W = WID_W + 1;

  logic [1:0]       shift;
  logic [EXT_W-1:0] ppt_mask;
  logic [EXT_W-1:0] rounded;
  logic [EXT_W-1:0] rem_pix;

  always_comb begin
    shift    = bpp_log2(depth);
    ppt_mask = EXT_W'((TILE_BYTES >> shift) - 1);
    rounded  = {1'b0, width_pix} + ppt_mask;
    tiles    = WID_W'(rounded >> (TILE_SHIFT - int'(shift)));
    rem_pix  = {1'b0, width_pix} & ppt_mask;
    if (rem_pix == '0)
      last_len = LEN_W'(TILE_BYTES);
    else
      last_len = LEN_W'(rem_pix << shift);
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sof,
  input  logic cfg_dma_en,
  input  logic cfg_fifo_rst,
  output logic dma_active,
  output logic fifo_flush
);
  logic fifo_rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_active <= 1'b0;
      fifo_rst_q <= 1'b0;
      fifo_flush <= 1'b0;
    end else begin
      if (sof) dma_active <= cfg_dma_en;
      fifo_rst_q <= cfg_fifo_rst;
      fifo_flush <= fifo_rst_q & ~cfg_fifo_rst;
    end
  end
endmodule

// File: rtl/scan_walker.sv
module scan_walker
  import scan_addr_pkg::*;
#(
  parameter int PTR_W = 23,
  parameter int WID_W = 12,
  parameter int HGT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic             sol,
  input  logic             run,
  input  logic [PTR_W-1:0] ptr_in,
  input  logic [WID_W-1:0] tiles_in,
  input  logic [LEN_W-1:0] last_in,
  input  logic [HGT_W-1:0] height_in,
  input  logic             linear_in,
  input  logic             req_ready,
  output logic [PTR_W-1:0] blk,
  output logic [LEN_W-1:0] len,
  output logic             valid
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(TILE_BYTES);

  logic [WID_W-1:0] lat_tiles;
  logic [LEN_W-1:0] lat_last;
  logic [HGT_W-1:0] lat_h;
  logic             lat_linear;
  logic [HGT_W-1:0] line_y;
  logic [WID_W-1:0] tile_t;
  logic [PTR_W-1:0] line_blk;
  logic [PTR_W-1:0] tile_step;
  logic [PTR_W-1:0] line_step;
  logic             last_tile;
  logic             next_is_last;

  always_comb begin
    tile_step    = lat_linear ? PTR_W'(1) : PTR_W'(lat_h);
    line_step    = lat_linear ? PTR_W'(lat_tiles) : PTR_W'(1);
    last_tile    = (tile_t == lat_tiles - 1'b1);
    next_is_last = (({1'b0, tile_t} + 2'd2) == {1'b0, lat_tiles});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid      <= 1'b0;
      blk        <= '0;
      len        <= '0;
      lat_tiles  <= '0;
      lat_last   <= '0;
      lat_h      <= '0;
      lat_linear <= 1'b0;
      line_y     <= '0;
      tile_t     <= '0;
      line_blk   <= '0;
    end else if (sof) begin
      valid      <= 1'b0;
      line_y     <= '0;
      tile_t     <= '0;
      line_blk   <= ptr_in;
      lat_tiles  <= tiles_in;
      lat_last   <= last_in;
      lat_h      <= height_in;
      lat_linear <= linear_in;
    end else if (valid) begin
      if (req_ready) begin
        if (last_tile) begin
          valid    <= 1'b0;
          line_y   <= line_y + 1'b1;
          line_blk <= line_blk + line_step;
        end else begin
          tile_t <= tile_t + 1'b1;
          blk    <= blk + tile_step;
          len    <= next_is_last ? lat_last : FULL;
        end
      end
    end else if (sol && run && (line_y < lat_h) && (lat_tiles != '0)) begin
      valid  <= 1'b1;
      tile_t <= '0;
      blk    <= line_blk;
      len    <= (lat_tiles == WID_W'(1)) ? lat_last : FULL;
    end
  end
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import scan_addr_pkg::*;
#(
  parameter int PTR_W = 23,
  parameter int WID_W = 12,
  parameter int HGT_W = 11,
  localparam int ADDR_W = PTR_W + TILE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  cfg_tile_ptr,
  input  logic [WID_W-1:0]  cfg_width_pix,
  input  logic [HGT_W-1:0]  cfg_height,
  input  logic [1:0]        cfg_depth,
  input  logic              cfg_linear,
  input  logic              cfg_dma_en,
  input  logic              cfg_fifo_rst,
  input  logic              sof,
  input  logic              sol,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              req_valid,
  output logic              dma_active,
  output logic              fifo_flush
);
  logic [WID_W-1:0] geo_tiles;
  logic [LEN_W-1:0] geo_last;
  logic [PTR_W-1:0] cur_blk;

  scan_geom #(.WID_W(WID_W)) u_geom (
    .depth     (cfg_depth),
    .width_pix (cfg_width_pix),
    .tiles     (geo_tiles),
    .last_len  (geo_last)
  );

  scan_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sof          (sof),
    .cfg_dma_en   (cfg_dma_en),
    .cfg_fifo_rst (cfg_fifo_rst),
    .dma_active   (dma_active),
    .fifo_flush   (fifo_flush)
  );

  scan_walker #(.PTR_W(PTR_W), .WID_W(WID_W), .HGT_W(HGT_W)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .sof       (sof),
    .sol       (sol),
    .run       (dma_active),
    .ptr_in    (cfg_tile_ptr),
    .tiles_in  (geo_tiles),
    .last_in   (geo_last),
    .height_in (cfg_height),
    .linear_in (cfg_linear),
    .req_ready (req_ready),
    .blk       (cur_blk),
    .len       (req_len),
    .valid     (req_valid)
  );

  assign req_addr = {cur_blk, {TILE_SHIFT{1'b0}}};
endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sof,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [9:0]        req_len,
  input logic              req_valid,
  input logic              dma_active,
  input logic              fifo_flush
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !sof) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

  assert_enable_at_frame_R7: assert property (@(posedge clk) disable iff (rst)
    (dma_active != $past(dma_active)) |-> $past(sof));

  assert_no_req_idle_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> dma_active);

  assert_len_range_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != 10'd0 && req_len <= 10'd512));

  assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[8:0] == 9'd0));

  assert_flush_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |=> !fifo_flush);

  assert_sof_abort_R11: assert property (@(posedge clk) disable iff (rst)
    sof |=> !req_valid);
endmodule

bind scan_addr_gen scan_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sof        (sof),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .req_valid  (req_valid),
  .dma_active (dma_active),
  .fifo_flush (fifo_flush)
);

// File: tb/scan_addr_gen_test.sv
`timescale 1ns/1ps
module scan_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [22:0] cfg_tile_ptr = '0;
  logic [11:0] cfg_width_pix = '0;
  logic [10:0] cfg_height = '0;
  logic [1:0]  cfg_depth = '0;
  logic        cfg_linear = 1'b0;
  logic        cfg_dma_en = 1'b0;
  logic        cfg_fifo_rst = 1'b0;
  logic        sof = 1'b0;
  logic        sol = 1'b0;
  logic        req_ready = 1'b1;
  logic [31:0] req_addr;
  logic [9:0]  req_len;
  logic        req_valid;
  logic        dma_active;
  logic        fifo_flush;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  scan_addr_gen uut (
    .clk(clk), .rst(rst), .cfg_tile_ptr(cfg_tile_ptr), .cfg_width_pix(cfg_width_pix),
    .cfg_height(cfg_height), .cfg_depth(cfg_depth), .cfg_linear(cfg_linear),
    .cfg_dma_en(cfg_dma_en), .cfg_fifo_rst(cfg_fifo_rst), .sof(sof), .sol(sol),
    .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len), .req_valid(req_valid),
    .dma_active(dma_active), .fifo_flush(fifo_flush)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] baddr(input int blk);
    return 32'(blk) << 9;
  endfunction

  task automatic frame_start();
    @(negedge clk) sof = 1'b1;
    @(negedge clk) sof = 1'b0;
  endtask

  // One line with ready high: burst i at blk first + i*step
  task automatic fetch_line(input int first, input int step, input int ntiles,
                            input int lastlen, input string tag);
    @(negedge clk) sol = 1'b1;
    @(negedge clk) sol = 1'b0;
    for (int i = 0; i < ntiles; i++) begin
      check({tag, " valid"}, 32'(req_valid), 32'd1);
      check({tag, " addr"}, req_addr, baddr(first + i * step));
      check({tag, " len"}, 32'(req_len), (i == ntiles - 1) ? 32'(lastlen) : 32'd512);
      @(negedge clk);
    end
    check({tag, " end"}, 32'(req_valid), 32'd0);
  endtask

  task automatic configure(input int ptr, input int wid, input int h,
                           input int dep, input bit lin);
    @(negedge clk);
    cfg_tile_ptr = 23'(ptr); cfg_width_pix = 12'(wid); cfg_height = 11'(h);
    cfg_depth = 2'(dep); cfg_linear = lin;
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(req_valid), 0);
    check("R1 active", 32'(dma_active), 0);
    check("R1 flush", 32'(fifo_flush), 0);
  endtask

  task automatic t_enable_wait();
    configure(32'h100, 1000, 4, 0, 0);
    cfg_dma_en = 1'b1;
    @(negedge clk) sol = 1'b1;
    @(negedge clk) sol = 1'b0;
    check("R7 inactive before sof", 32'(dma_active), 0);
    check("R7 no req inactive", 32'(req_valid), 0);
    frame_start();
    check("R7 active after sof", 32'(dma_active), 1);
  endtask

  task automatic t_tiled8();
    // 8-bit: 512 px per tile, 1000 px -> 2 tiles, last 488 bytes; step H=4
    fetch_line(32'h100, 4, 2, 488, "R3 R2 tiled8 y0");
    fetch_line(32'h101, 4, 2, 488, "R3 R5 tiled8 y1");
  endtask

  task automatic t_tiled16();
    configure(32'h200, 600, 8, 1, 0);
    frame_start();
    // 256 px per tile -> 3 tiles, 88 px leftover -> 176 bytes
    fetch_line(32'h200, 8, 3, 176, "R2 R5 tiled16");
  endtask

  task automatic t_tiled32();
    configure(32'h40, 256, 5, 2, 0);
    frame_start();
    fetch_line(32'h40, 5, 2, 512, "R5 tiled32 exact");
    configure(32'h40, 200, 5, 3, 0);
    frame_start();
    // code 3 also 4 bytes: 128 px per tile, 200 px -> 2 tiles, 72 px -> 288 bytes
    fetch_line(32'h40, 5, 2, 288, "R2 depth3");
  endtask

  task automatic t_linear();
    configure(32'h300, 1000, 4, 0, 1);
    frame_start();
    fetch_line(32'h300, 1, 2, 488, "R4 linear y0");
    fetch_line(32'h302, 1, 2, 488, "R4 linear y1");
  endtask

  task automatic t_midframe_cfg();
    configure(32'h100, 1000, 4, 0, 0);
    frame_start();
    configure(32'h555, 600, 9, 1, 1);
    fetch_line(32'h100, 4, 2, 488, "R8 cfg held");
    frame_start();
    fetch_line(32'h555, 1, 3, 176, "R8 cfg after sof");
  endtask

  task automatic t_height_busy();
    configure(32'h80, 1000, 2, 0, 0);
    frame_start();
    fetch_line(32'h80, 2, 2, 488, "R9 line0");
    // sol during a held line is ignored
    req_ready = 1'b0;
    @(negedge clk) sol = 1'b1;
    @(negedge clk) sol = 1'b0;
    check("R6 first req", req_addr, baddr(32'h81));
    @(negedge clk) sol = 1'b1;
    @(negedge clk) sol = 1'b0;
    check("R6 hold valid", 32'(req_valid), 1);
    check("R9 sol while busy", req_addr, baddr(32'h81));
    req_ready = 1'b1;
    @(negedge clk);
    check("R6 next tile", req_addr, baddr(32'h83));
    check("R6 next len", 32'(req_len), 488);
    @(negedge clk);
    check("R6 line done", 32'(req_valid), 0);
    @(negedge clk) sol = 1'b1;
    @(negedge clk) sol = 1'b0;
    check("R9 beyond height", 32'(req_valid), 0);
    @(negedge clk);
    check("R9 beyond height later", 32'(req_valid), 0);
  endtask

  task automatic t_sof_abort();
    configure(32'h100, 1000, 4, 0, 0);
    frame_start();
    fetch_line(32'h100, 4, 2, 488, "R11 pre");
    req_ready = 1'b0;
    @(negedge clk) sol = 1'b1;
    @(negedge clk) sol = 1'b0;
    check("R11 in flight", req_addr, baddr(32'h101));
    frame_start();
    check("R11 dropped", 32'(req_valid), 0);
    req_ready = 1'b1;
    fetch_line(32'h100, 4, 2, 488, "R11 restart y0");
  endtask

  task automatic t_disable();
    cfg_dma_en = 1'b0;
    fetch_line(32'h101, 4, 2, 488, "R7 finish frame");
    check("R7 still active", 32'(dma_active), 1);
    frame_start();
    check("R7 inactive", 32'(dma_active), 0);
    @(negedge clk) sol = 1'b1;
    @(negedge clk) sol = 1'b0;
    check("R7 no req disabled", 32'(req_valid), 0);
  endtask

  task automatic t_flush();
    @(negedge clk) cfg_fifo_rst = 1'b1;
    @(negedge clk);
    check("R10 no flush while set", 32'(fifo_flush), 0);
    cfg_fifo_rst = 1'b0;
    @(negedge clk);
    check("R10 flush pulse", 32'(fifo_flush), 1);
    @(negedge clk);
    check("R10 flush one cycle", 32'(fifo_flush), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable_wait();
    t_tiled8();
    t_tiled16();
    t_tiled32();
    t_linear();
    t_midframe_cfg();
    t_height_busy();
    t_sof_abort();
    t_disable();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule